// File: doc/BRIEF.md
# Keyboard Port First-Clock-Edge Interrupt

This block watches the clock line of a two-wire keyboard port and tracks frame progress in both directions. It keeps a 4-bit receive bit counter and a 4-bit transmit bit counter. It raises a sticky flag on the first falling clock edge of every frame, whichever direction the frame travels. The flag drives an optional interrupt request and a one-cycle wake request, so a system sitting in a low-power state is woken as soon as a frame begins rather than when it ends.

The raw clock line is resynchronized inside the block, and a falling-edge detector turns each fall into a single-cycle pulse. That pulse steps whichever counter is enabled. Receive counting is enabled by the port enable together with the receive enable. Transmit counting is enabled by the port enable together with an internal transmit-active bit, which software starts with a strobe. When the 11th edge closes a frame, the counter returns to zero. At the end of a transmit frame, transmit-active clears and a sticky transmit-end bit sets. Software tells the direction of an interrupt from these bits: the receive enable points to reception, and transmit-active or transmit-end points to transmission.

Frame decoding, parity, data shifting and line driving belong to neighbouring logic. All pins are plain control and status pins; no data stream crosses the block edge, so there is no valid/ready handshake.

Top module: `kbd_edge_irq`

## Requirements
- R1: After reset, edge_flag, irq, wake_req, tx_active and tx_done are 0, and rx_cnt and tx_cnt are 0000.
- R2: With io_en=1 and rx_en=1, a falling clock edge while rx_cnt=0000 sets edge_flag in the same cycle that rx_cnt changes from 0000 to 0001.
- R3: With io_en=1 and tx_active=1, a falling clock edge while tx_cnt=0000 sets edge_flag in the same cycle that tx_cnt changes from 0000 to 0001.
- R4: Every further falling edge of an enabled direction adds one to its counter (0001, 0010, ...), and edge_flag is not re-raised during the frame.
- R5: irq is 1 exactly when edge_flag=1 and irq_en=1.
- R6: edge_flag stays set until a flag_clr pulse clears it.
- R7: The 11th falling edge of a frame returns that counter to 0000. For transmit, it also clears tx_active and sets tx_done. The next first edge raises edge_flag again.
- R8: Falling edges seen while a direction's two enables are not both 1 leave its counter, edge_flag and wake_req unchanged. Dropping an enable returns that counter to 0000.
- R9: wake_req is a one-cycle pulse, issued once for each first edge in the cycle edge_flag is set.
- R10: A tx_go pulse sets tx_active and clears tx_done.
- R11: The line passes through a two-flop synchronizer, and each fall of the line yields exactly one counter step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kclk_in | input | 1 | Raw keyboard clock line (idle high) |
| io_en | input | 1 | Port enable |
| rx_en | input | 1 | Receive enable |
| tx_go | input | 1 | Transmit start strobe |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Flag clear strobe |
| edge_flag | output | 1 | First-edge flag (sticky) |
| irq | output | 1 | Interrupt request |
| rx_cnt | output | 4 | Receive bit counter |
| tx_cnt | output | 4 | Transmit bit counter |
| tx_active | output | 1 | Transmit in progress; clears itself at frame end |
| tx_done | output | 1 | Transmit-end status (sticky) |
| wake_req | output | 1 | One-cycle wake request |

## Verification
The bench records the exact cycle where the flag rises and the cycle where each counter leaves zero, and it requires the two to match. A design that flagged one cycle late, or on frame completion, fails this check. It runs full 11-edge frames in both directions and then starts a fresh frame. A counter that wrapped at 16, failed to clear transmit-active, or failed to re-arm the flag shows up there. Edges sent with only one of the two enables set must leave the counters, flag and wake count untouched. A design that counted on either enable alone would change them.

// File: rtl/kbd_edge_pkg.sv
package kbd_edge_pkg;
  typedef enum logic [0:0] {DIR_RX = 1'b0, DIR_TX = 1'b1} dir_e;
  localparam int unsigned NUM_DIR = 2;
endpackage

// File: rtl/kbd_clk_fall.sv
module kbd_clk_fall #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic fall_pulse
);
  // sync chain plus one history stage for the edge compare
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b1;
    else        chain[0] <= line_in;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= 1'b1;
      else        chain[g] <= chain[g-1];
    end
  end

  assign fall_pulse = chain[STAGES] & ~chain[STAGES-1];

  // one fall of the line gives a single-cycle pulse
  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fall_pulse |=> !fall_pulse);
endmodule

// File: rtl/kbd_bit_counter.sv
module kbd_bit_counter #(
  parameter int unsigned W     = 4,
  parameter int unsigned EDGES = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         first_evt,
  output logic         wrap_evt
);
  localparam logic [W-1:0] LAST = W'(EDGES - 1);

  assign first_evt = enable & step & (cnt == '0);
  assign wrap_evt  = enable & step & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!enable)  cnt <= '0;
    else if (wrap_evt) cnt <= '0;
    else if (step)     cnt <= cnt + 1'b1;
  end

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && step && cnt != LAST) |=> cnt == $past(cnt) + 1'b1);
  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && step && cnt == LAST) |=> cnt == '0);
  assert_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> cnt == '0);
endmodule

// File: rtl/kbd_edge_flag.sv
module kbd_edge_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  output logic flag,
  output logic wake_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      flag     <= set_evt | (flag & ~clr);
      wake_req <= set_evt;
    end
  end

  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  assert_wake_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> flag);
endmodule

// File: rtl/kbd_edge_irq.sv
module kbd_edge_irq
  import kbd_edge_pkg::*;
#(
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned FRAME_EDGES = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kclk_in,
  input  logic             io_en,
  input  logic             rx_en,
  input  logic             tx_go,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic             edge_flag,
  output logic             irq,
  output logic [CNT_W-1:0] rx_cnt,
  output logic [CNT_W-1:0] tx_cnt,
  output logic             tx_active,
  output logic             tx_done,
  output logic             wake_req
);
  logic                 fall;
  logic [NUM_DIR-1:0]   dir_en;
  logic [NUM_DIR-1:0]   first_evt;
  logic [NUM_DIR-1:0]   wrap_evt;
  logic [CNT_W-1:0]     cnt_q [NUM_DIR];

  kbd_clk_fall #(.STAGES(SYNC_STAGES)) u_fall (
    .clk(clk), .rst_n(rst_n), .line_in(kclk_in), .fall_pulse(fall));

  assign dir_en[DIR_RX] = io_en & rx_en;
  assign dir_en[DIR_TX] = io_en & tx_active;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    kbd_bit_counter #(.W(CNT_W), .EDGES(FRAME_EDGES)) u_cnt (
      .clk(clk), .rst_n(rst_n), .enable(dir_en[d]), .step(fall),
      .cnt(cnt_q[d]), .first_evt(first_evt[d]), .wrap_evt(wrap_evt[d]));
  end

  assign rx_cnt = cnt_q[DIR_RX];
  assign tx_cnt = cnt_q[DIR_TX];

  kbd_edge_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_evt(|first_evt), .clr(flag_clr),
    .flag(edge_flag), .wake_req(wake_req));

  assign irq = edge_flag & irq_en;

  // transmit start bit clears itself at frame end; end status stays
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_active <= 1'b0;
      tx_done   <= 1'b0;
    end else if (wrap_evt[DIR_TX]) begin
      tx_active <= 1'b0;
      tx_done   <= 1'b1;
    end else if (tx_go) begin
      tx_active <= 1'b1;
      tx_done   <= 1'b0;
    end
  end

  initial assert_frame_fits_R7: assert (FRAME_EDGES <= (1 << CNT_W) && FRAME_EDGES > 1);

  assert_rx_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_cnt) == '0 && rx_cnt == CNT_W'(1)) |-> edge_flag);
  assert_tx_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_cnt) == '0 && tx_cnt == CNT_W'(1)) |-> edge_flag);
  assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (edge_flag && irq_en));
  assert_tx_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_active) |-> (tx_done && tx_cnt == '0));
  assert_tx_go_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_go && !wrap_evt[DIR_TX]) |=> (tx_active && !tx_done));
endmodule

// File: tb/test_kbd_edge_irq.sv
module test_kbd_edge_irq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0, rst_n = 1'b0, kclk_in = 1'b1;
  logic io_en = 1'b0, rx_en = 1'b0, tx_go = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
  logic edge_flag, irq, tx_active, tx_done, wake_req;
  logic [3:0] rx_cnt, tx_cnt;

  int errors = 0, checks = 0, cyc = 0, wakes = 0;
  int cyc_flag = -1, cyc_rx1 = -1, cyc_tx1 = -1;
  logic prev_flag = 1'b0;
  logic [3:0] prev_rx = 4'd0, prev_tx = 4'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_edge_irq i_kbd_edge_irq (
    .clk(clk), .rst_n(rst_n), .kclk_in(kclk_in), .io_en(io_en), .rx_en(rx_en),
    .tx_go(tx_go), .irq_en(irq_en), .flag_clr(flag_clr), .edge_flag(edge_flag),
    .irq(irq), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .tx_active(tx_active),
    .tx_done(tx_done), .wake_req(wake_req));

  // port-level monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (wake_req) wakes <= wakes + 1;
      if (edge_flag && !prev_flag) cyc_flag <= cyc;
      if (rx_cnt == 4'd1 && prev_rx == 4'd0) cyc_rx1 <= cyc;
      if (tx_cnt == 4'd1 && prev_tx == 4'd0) cyc_tx1 <= cyc;
    end
    prev_flag <= edge_flag;
    prev_rx   <= rx_cnt;
    prev_tx   <= tx_cnt;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ps2_fall();
    @(negedge clk) kclk_in = 1'b0;
    repeat (6) @(negedge clk);
    kclk_in = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 flag", edge_flag, 0);
    check("R1 irq", irq, 0);
    check("R1 wake", wake_req, 0);
    check("R1 rx_cnt", rx_cnt, 0);
    check("R1 tx_cnt", tx_cnt, 0);
    check("R1 tx_active", tx_active, 0);
    check("R1 tx_done", tx_done, 0);
  endtask

  task automatic t_rx_frame();
    io_en = 1'b1; rx_en = 1'b1; irq_en = 1'b0;
    ps2_fall();
    check("R2 rx_cnt after first edge", rx_cnt, 1);
    check("R2 flag after first edge", edge_flag, 1);
    check("R2 flag rise cycle equals rx 0->1 cycle", cyc_flag, cyc_rx1);
    check("R5 irq masked", irq, 0);
    check("R9 wake pulses", wakes, 1);
    @(negedge clk) irq_en = 1'b1;
    @(negedge clk);
    check("R5 irq enabled", irq, 1);
    for (int i = 0; i < 9; i++) ps2_fall();
    check("R4 rx_cnt after 10 edges", rx_cnt, 10);
    check("R4 no extra wake in frame", wakes, 1);
    check("R6 flag held", edge_flag, 1);
    clear_flag();
    check("R6 flag cleared", edge_flag, 0);
    check("R5 irq follows flag", irq, 0);
    ps2_fall();
    check("R7 rx_cnt wraps on 11th edge", rx_cnt, 0);
    check("R7 no flag on 11th edge", edge_flag, 0);
    ps2_fall();
    check("R7 next frame count", rx_cnt, 1);
    check("R7 next frame flag", edge_flag, 1);
    check("R9 second wake", wakes, 2);
    ps2_fall();
    @(negedge clk) rx_en = 1'b0;
    @(negedge clk);
    check("R8 rx_cnt reset by disable", rx_cnt, 0);
    clear_flag();
  endtask

  task automatic t_ignored();
    io_en = 1'b1; rx_en = 1'b0;
    ps2_fall();
    io_en = 1'b0; rx_en = 1'b1;
    ps2_fall();
    ps2_fall();
    check("R8 rx_cnt unchanged", rx_cnt, 0);
    check("R8 tx_cnt unchanged", tx_cnt, 0);
    check("R8 flag unchanged", edge_flag, 0);
    check("R8 no wake", wakes, 2);
    rx_en = 1'b0; io_en = 1'b1;
  endtask

  task automatic t_tx_frame();
    @(negedge clk) tx_go = 1'b1;
    @(negedge clk) tx_go = 1'b0;
    check("R10 tx_active set", tx_active, 1);
    check("R10 tx_done low", tx_done, 0);
    ps2_fall();
    check("R3 tx_cnt after first edge", tx_cnt, 1);
    check("R3 flag", edge_flag, 1);
    check("R3 flag rise cycle equals tx 0->1 cycle", cyc_flag, cyc_tx1);
    check("R11 rx idle during tx", rx_cnt, 0);
    for (int i = 0; i < 9; i++) ps2_fall();
    check("R4 tx_cnt after 10 edges", tx_cnt, 10);
    check("R7 tx_active before end", tx_active, 1);
    ps2_fall();
    check("R7 tx_cnt wraps", tx_cnt, 0);
    check("R7 tx_active cleared", tx_active, 0);
    check("R7 tx_done set", tx_done, 1);
    ps2_fall();
    check("R8 tx idle after end", tx_cnt, 0);
    check("R7 tx_done sticky", tx_done, 1);
    @(negedge clk) tx_go = 1'b1;
    @(negedge clk) tx_go = 1'b0;
    check("R10 tx_done cleared by start", tx_done, 0);
    check("R10 tx_active again", tx_active, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_rx_frame();
    t_ignored();
    t_tx_frame();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule